// File: doc/BRIEF.md
# Saturating rounding narrowing shifter

This block narrows a 128-bit packed vector of integer lanes into a 64-bit packed result. Each source lane is shifted right by an immediate amount with round-to-nearest, then clamped to a lane half its width. One 6-bit immediate field selects both the lane size and the shift distance. Two mode flags, `u_flag` and `op_flag`, pick the signedness of the source and of the destination. Three modes are supported: signed to signed, unsigned to unsigned, and signed to unsigned. In the signed-to-unsigned mode, negative lanes clamp to zero.

Each operation is presented together with a one-cycle `issue` strobe. The result, a per-operation saturation bit and an illegal-operand bit are registered at that clock edge. A sticky saturation flag collects every clamp until it is cleared through a synchronous clear input.

Top module: `sat_narrow_shifter`

## Requirements
- R1: The top three bits of `imm_field` choose the result lane width H: `1xxxxx` gives 32 bits, `01xxxx` gives 16 bits and `001xxx` gives 8 bits. The source lanes are 2H bits wide. Result lane e sits at bits [e*H +: H] of `res_vec` and comes from source bits [e*2H +: 2H].
- R2: The shift distance is 2H minus the unsigned value of `imm_field`, which gives a range of 1 to H.
- R3: Before the shift, each lane is rounded by adding 2^(shift-1). This addition is done at full precision, so an all-ones unsigned lane does not wrap.
- R4: Source lanes are read as unsigned only when `u_flag`=1 and `op_flag`=1. In every other case they are two's complement.
- R5: The destination is unsigned when `u_flag`=1 and two's complement when `u_flag`=0.
- R6: A rounded value outside the destination range is clamped to that range's minimum or maximum. For an unsigned destination, every negative value becomes 0.
- R7: `res_sat` is 1 in the cycle after a legal issued operation in which at least one lane was clamped. In every other cycle it is 0.
- R8: `sat_sticky` goes to 1 whenever `res_sat` is set, and it holds that value until `sat_clear` is sampled high. If a clamp and a clear arrive in the same cycle, the clamp wins.
- R9: An operand is illegal when the top three bits of `imm_field` are 000, or when `u_flag`=0 and `op_flag`=0. An issued illegal operand gives `res_illegal`=1, `res_vec`=0 and `res_sat`=0, and it leaves `sat_sticky` unchanged.
- R10: After reset, `res_vec`, `res_sat`, `res_illegal` and `sat_sticky` are all 0.
- R11: Outputs change only at the clock edge that samples `issue`=1. In other cycles `res_vec` holds its value, and `res_sat` and `res_illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | One operation is presented this cycle |
| src_vec | input | 128 | Packed source lanes |
| imm_field | input | 6 | Selects the lane size and the shift distance |
| u_flag | input | 1 | Destination unsigned; together with `op_flag`, source unsigned |
| op_flag | input | 1 | Mode flag (see R4, R9) |
| sat_clear | input | 1 | Synchronous clear of the sticky flag |
| res_vec | output | 64 | Packed narrowed result |
| res_sat | output | 1 | The last issued operation clamped at least one lane |
| res_illegal | output | 1 | The last issued operation had an illegal operand |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
Every result, including the sticky flag, appears exactly one clock edge after the edge that samples `issue`. No output has a combinational path from the inputs. The bench drives each operation on a falling edge and samples the outputs on the following falling edge. At that point its behavioural model has already absorbed the same rising edge. Cycles without an issue are checked the same way, to confirm that the result holds and the per-operation flags drop.

// File: rtl/snr_pkg.sv
package snr_pkg;

  typedef enum logic [1:0] {SZ_NONE, SZ_8, SZ_16, SZ_32} res_size_e;

  typedef struct packed {
    res_size_e  size;
    logic [5:0] shamt;
    logic       src_uns;
    logic       dst_uns;
    logic       illegal;
  } op_dec_t;

  localparam int NUM_SIZES = 3;

  // Size, shift distance and mode from the immediate and flags.
  function automatic op_dec_t decode_op(input logic [5:0] imm, input logic u, input logic op);
    op_dec_t d;
    logic [6:0] twice_h;
    d = '0;
    twice_h = 7'd0;
    if (imm[5]) begin
      d.size = SZ_32; twice_h = 7'd64;
    end else if (imm[4]) begin
      d.size = SZ_16; twice_h = 7'd32;
    end else if (imm[3]) begin
      d.size = SZ_8; twice_h = 7'd16;
    end
    d.shamt   = 6'(twice_h - {1'b0, imm});
    d.src_uns = u & op;
    d.dst_uns = u;
    d.illegal = (d.size == SZ_NONE) || (!u && !op);
    return d;
  endfunction

endpackage

// File: rtl/snr_decode.sv
module snr_decode
  import snr_pkg::*;
(
  input  logic [5:0] imm_field,
  input  logic       u_flag,
  input  logic       op_flag,
  output op_dec_t    dec
);
  always_comb dec = decode_op(imm_field, u_flag, op_flag);
endmodule

// File: rtl/snr_lane.sv
module snr_lane #(
  parameter int SRC_W = 16
) (
  input  logic [SRC_W-1:0]   lane_in,
  input  logic [5:0]         shamt,
  input  logic               src_uns,
  input  logic               dst_uns,
  output logic [SRC_W/2-1:0] lane_out,
  output logic               lane_sat
);
  localparam int H  = SRC_W / 2;
  localparam int EW = SRC_W + 2;
  localparam logic signed [EW-1:0] SMAX = {{(EW-H+1){1'b0}}, {(H-1){1'b1}}};
  localparam logic signed [EW-1:0] SMIN = {{(EW-H+1){1'b1}}, {(H-1){1'b0}}};
  localparam logic signed [EW-1:0] UMAX = {{(EW-H){1'b0}}, {H{1'b1}}};

  logic signed [EW-1:0] ext_val, half_lsb, rounded, shifted;
  logic too_low, too_high;

  always_comb begin
    if (src_uns) ext_val = {2'b00, lane_in};
    else         ext_val = {{2{lane_in[SRC_W-1]}}, lane_in};
    half_lsb = EW'(1) <<< (shamt - 6'd1);
    rounded  = ext_val + half_lsb;
    shifted  = rounded >>> shamt;
  end

  always_comb begin
    if (dst_uns) begin
      too_low  = shifted[EW-1];
      too_high = !shifted[EW-1] && (shifted > UMAX);
    end else begin
      too_low  = shifted < SMIN;
      too_high = shifted > SMAX;
    end
    lane_sat = too_low | too_high;
    if (too_low)       lane_out = dst_uns ? '0 : SMIN[H-1:0];
    else if (too_high) lane_out = dst_uns ? UMAX[H-1:0] : SMAX[H-1:0];
    else               lane_out = shifted[H-1:0];
  end
endmodule

// File: rtl/snr_lane_bank.sv
module snr_lane_bank #(
  parameter int VEC_W = 128,
  parameter int SRC_W = 16
) (
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [5:0]         shamt,
  input  logic               src_uns,
  input  logic               dst_uns,
  output logic [VEC_W/2-1:0] res_vec,
  output logic               any_sat
);
  localparam int H = SRC_W / 2;
  localparam int N = VEC_W / SRC_W;

  logic [N-1:0] lane_sat;

  for (genvar e = 0; e < N; e++) begin : g_lane
    snr_lane #(.SRC_W(SRC_W)) u_lane (
      .lane_in (src_vec[e*SRC_W +: SRC_W]),
      .shamt   (shamt),
      .src_uns (src_uns),
      .dst_uns (dst_uns),
      .lane_out(res_vec[e*H +: H]),
      .lane_sat(lane_sat[e])
    );
  end

  assign any_sat = |lane_sat;
endmodule

// File: rtl/sat_narrow_shifter.sv
module sat_narrow_shifter
  import snr_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [5:0]         imm_field,
  input  logic               u_flag,
  input  logic               op_flag,
  input  logic               sat_clear,
  output logic [VEC_W/2-1:0] res_vec,
  output logic               res_sat,
  output logic               res_illegal,
  output logic               sat_sticky
);
  localparam int OUT_W = VEC_W / 2;

  op_dec_t dec;
  logic [OUT_W-1:0] bank_res [NUM_SIZES];
  logic [NUM_SIZES-1:0] bank_sat;
  logic [OUT_W-1:0] sel_res;
  logic sel_sat;

  // Named events for the checker.
  logic cur_illegal, cur_any_sat, cur_set;

  snr_decode u_dec (
    .imm_field(imm_field),
    .u_flag   (u_flag),
    .op_flag  (op_flag),
    .dec      (dec)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
    snr_lane_bank #(.VEC_W(VEC_W), .SRC_W(16 << g)) u_bank (
      .src_vec(src_vec),
      .shamt  (dec.shamt),
      .src_uns(dec.src_uns),
      .dst_uns(dec.dst_uns),
      .res_vec(bank_res[g]),
      .any_sat(bank_sat[g])
    );
  end

  always_comb begin
    unique case (dec.size)
      SZ_8:    begin sel_res = bank_res[0]; sel_sat = bank_sat[0]; end
      SZ_16:   begin sel_res = bank_res[1]; sel_sat = bank_sat[1]; end
      SZ_32:   begin sel_res = bank_res[2]; sel_sat = bank_sat[2]; end
      default: begin sel_res = '0;          sel_sat = 1'b0;        end
    endcase
  end

  assign cur_illegal = dec.illegal;
  assign cur_any_sat = sel_sat & ~dec.illegal;
  assign cur_set     = issue & cur_any_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vec     <= '0;
      res_sat     <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      res_sat     <= cur_set;
      res_illegal <= issue & cur_illegal;
      if (issue) res_vec <= cur_illegal ? '0 : sel_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sat_sticky <= 1'b0;
    else if (cur_set)   sat_sticky <= 1'b1;
    else if (sat_clear) sat_sticky <= 1'b0;
  end
endmodule

// File: rtl/snr_chk.sv
module snr_chk #(
  parameter int OUT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic [5:0]       imm_field,
  input logic             u_flag,
  input logic             op_flag,
  input logic             sat_clear,
  input logic [OUT_W-1:0] res_vec,
  input logic             res_sat,
  input logic             res_illegal,
  input logic             sat_sticky,
  input logic             cur_illegal,
  input logic             cur_set
);
  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (res_vec == '0 && !res_sat));
  // R9
  illegal_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (imm_field[5:3] == 3'b000 || (!u_flag && !op_flag)) |=> res_illegal);
  // R9
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && cur_illegal && !sat_clear |=> $stable(sat_sticky));
  // R8
  sticky_follows_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_sat |-> sat_sticky);
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky && !sat_clear |=> sat_sticky);
  // R8
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clear && !cur_set |=> !sat_sticky);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(res_vec) && !res_sat && !res_illegal));
endmodule

bind sat_narrow_shifter snr_chk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue      (issue),
  .imm_field  (imm_field),
  .u_flag     (u_flag),
  .op_flag    (op_flag),
  .sat_clear  (sat_clear),
  .res_vec    (res_vec),
  .res_sat    (res_sat),
  .res_illegal(res_illegal),
  .sat_sticky (sat_sticky),
  .cur_illegal(cur_illegal),
  .cur_set    (cur_set)
);

// File: tb/sat_narrow_shifter_bench.sv
module sat_narrow_shifter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0;
  logic [127:0] src_vec = '0;
  logic [5:0] imm_field = '0;
  logic u_flag = 1'b0, op_flag = 1'b0, sat_clear = 1'b0;
  logic [63:0] res_vec;
  logic res_sat, res_illegal, sat_sticky;

  int checks = 0;
  int failures = 0;

  logic [63:0] e_vec = '0;
  logic e_sat = 1'b0, e_ill = 1'b0, e_sticky = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_narrow_shifter u_sat_narrow_shifter (
    .clk(clk), .rst_n(rst_n), .issue(issue), .src_vec(src_vec),
    .imm_field(imm_field), .u_flag(u_flag), .op_flag(op_flag),
    .sat_clear(sat_clear), .res_vec(res_vec), .res_sat(res_sat),
    .res_illegal(res_illegal), .sat_sticky(sat_sticky)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: wide signed integer arithmetic per lane.
  function automatic logic [31:0] ref_lane(input logic [63:0] raw, input int h, input int sh,
                                           input bit s_uns, input bit d_uns, output bit sat);
    logic signed [71:0] v, lo, hi;
    logic [63:0] m;
    m = raw & ((64'd1 << (2*h)) - 64'd1);
    v = $signed({8'd0, m});
    if (!s_uns && m[2*h-1]) v = v - (72'sd1 <<< (2*h));
    v = (v + (72'sd1 <<< (sh-1))) >>> sh;
    if (d_uns) begin
      lo = 72'sd0; hi = (72'sd1 <<< h) - 72'sd1;
    end else begin
      lo = -(72'sd1 <<< (h-1)); hi = (72'sd1 <<< (h-1)) - 72'sd1;
    end
    sat = 1'b0;
    if (v < lo) begin v = lo; sat = 1'b1; end
    else if (v > hi) begin v = hi; sat = 1'b1; end
    return v[31:0] & ((32'd1 << h) - 32'd1);
  endfunction

  task automatic run(input logic iss, input logic [127:0] s, input logic [5:0] im,
                     input logic u, input logic o, input logic clr, input string tag);
    int h, sh;
    bit ill, any, ls;
    logic [63:0] acc;
    issue = iss; src_vec = s; imm_field = im; u_flag = u; op_flag = o; sat_clear = clr;
    h = im[5] ? 32 : (im[4] ? 16 : (im[3] ? 8 : 0));
    sh = 2*h - int'(im);
    ill = (h == 0) || (!u && !o);
    any = 1'b0;
    if (iss) begin
      if (ill) begin
        e_vec = '0; e_sat = 1'b0; e_ill = 1'b1;
      end else begin
        acc = '0;
        for (int e = 0; e < 64/h; e++) begin
          acc |= 64'(ref_lane(64'(s >> (e*2*h)), h, sh, u && o, u, ls)) << (e*h);
          any |= ls;
        end
        e_vec = acc; e_sat = any; e_ill = 1'b0;
      end
    end else begin
      e_sat = 1'b0; e_ill = 1'b0;
    end
    if (iss && !ill && any) e_sticky = 1'b1;
    else if (clr) e_sticky = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "res_vec", res_vec, e_vec);
    chk("R7", "res_sat", 64'(res_sat), 64'(e_sat));
    chk("R9", "res_illegal", 64'(res_illegal), 64'(e_ill));
    chk("R8", "sat_sticky", 64'(sat_sticky), 64'(e_sticky));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    repeat (2) @(negedge clk);
    chk("R10", "res_vec", res_vec, 64'd0);
    chk("R10", "res_sat", 64'(res_sat), 64'd0);
    chk("R10", "sat_sticky", 64'(sat_sticky), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "res_illegal", 64'(res_illegal), 64'd0);

    pat = 128'h0102_7F80_FFFD_8000_0003_00FF_7FFF_0001;
    // R1 R2: every size at both shift extremes, signed to signed
    run(1, pat, 6'd15, 0, 1, 0, "R1");
    run(1, pat, 6'd8,  0, 1, 0, "R2");
    run(1, pat, 6'd31, 0, 1, 0, "R1");
    run(1, pat, 6'd16, 0, 1, 0, "R2");
    run(1, pat, 6'd63, 0, 1, 0, "R1");
    run(1, pat, 6'd32, 0, 1, 0, "R2");
    run(0, rnd128(), 6'd40, 1, 1, 0, "R11");
    // R3 all-ones unsigned lanes must not wrap during rounding
    run(1, {128{1'b1}}, 6'd8,  1, 1, 0, "R3");
    run(1, {128{1'b1}}, 6'd32, 1, 1, 0, "R3");
    run(1, {8{16'h7F80}}, 6'd8, 0, 1, 0, "R3");
    // R4 source unsigned vs signed on the same pattern
    run(1, {8{16'hFF00}}, 6'd12, 1, 1, 0, "R4");
    run(1, {8{16'hFF00}}, 6'd12, 0, 1, 0, "R4");
    // R5 R6 signed source, unsigned destination: negatives become zero
    run(1, {4{32'hFFFF_0000}}, 6'd20, 1, 0, 0, "R5");
    run(1, {2{64'h8000_0000_0000_0000}}, 6'd63, 0, 1, 0, "R6");
    run(1, {2{64'h8000_0000_0000_0000}}, 6'd63, 1, 0, 0, "R6");
    // R9 illegal operands leave the sticky flag alone
    run(1, pat, 6'd5, 0, 1, 0, "R9");
    run(1, pat, 6'd40, 0, 0, 0, "R9");
    // R8 clear, then clamp and clear together
    run(0, pat, 6'd40, 0, 1, 1, "R8");
    run(1, {8{16'h7FFF}}, 6'd15, 0, 1, 1, "R8");
    run(1, {16'h0004, 112'd0}, 6'd13, 0, 1, 1, "R8");
    for (int i = 0; i < 400; i++) begin
      logic [5:0] im;
      im = 6'($urandom);
      if (($urandom % 8) != 0 && im[5:3] == 3'b000) im[3] = 1'b1;
      run(($urandom % 5) != 0, rnd128(), im, 1'($urandom), 1'($urandom),
          ($urandom % 6) == 0, "R1");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule